// File: doc/BRIEF.md
# Reset-Held Card ID and Diagnostic Multiplexer

This block drives the identification and status-return lines that a test card presents to two ports of a host test module. Index 0 of each per-port bus is the transmit-side port and index 1 is the receive-side port. Each port gets a 6-bit card-ID field, a 3-bit port-status field and a 2-bit summary-status field. The block has no software-visible registers. The host controls it only through an active-low master reset and two global diagnostic bits. It also samples a stream of transmit-FIFO words, so the host can push test patterns onto the ID and status lines and read them back.

After a master reset the block presents a fixed card ID on both ID fields. It keeps that ID until either diagnostic bit is raised. After that, each ID field carries one of two things: the low bits of the most recently accepted FIFO word, or that port's own control and mode lines. With both diagnostic bits high, the status fields of both ports echo the low five bits of the captured word. When echo stops, the status fields keep their last echoed value.

The FIFO words arrive on a valid/ready stream. Ready is always high and the block never applies back-pressure. A word transfers on any rising clock edge where valid is high. Data must be stable whenever valid is high.

Top module: `lb_diag_mux`

## Requirements
- R1: While `rst_n` is low, both ID fields equal `CARD_ID` (default 1), and every status output is 0. The capture register also clears to 0. The reset is asynchronous.
- R2: After reset, while neither diagnostic bit has been high at any rising edge and both bits are low, both ID fields stay at `CARD_ID`, whatever the word stream and the control lines do.
- R3: Raising either diagnostic bit takes the ID fields out of the card-ID value in the same cycle. Once a diagnostic bit has been high at a rising edge, the card ID does not come back without a new master reset. A new reset does bring it back.
- R4: With `diag0` high and `diag1` low, both ID fields equal bits 5..0 of the last word accepted before the current cycle (0 if none since reset).
- R5: With `diag1` high and `diag0` low, each port's ID field is {1'b0, port_ctl[p][2:0], port_ctl_n[p], port_mode[p]}. For example, control 5, control line 1 and mode 1 give 0x17.
- R6: With both diagnostic bits high, each port's status outputs follow the captured word in the same cycle: `pstat[p]` = word bits 4..2 and `srstat[p]` = word bits 1..0.
- R7: When the two diagnostic bits are not both high, the status outputs hold the value they had in the previous cycle. That value is 0 after reset.
- R8: When the two diagnostic bits are equal and the card ID is no longer shown, the ID fields use the source (word or port lines) of the most recent cycle that had exactly one diagnostic bit high. If no such cycle has occurred since reset, the source is the captured word.
- R9: `word_ready` is always 1. A word is captured only at a rising edge with `word_valid` high. Otherwise the capture register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| diag0 | input | 1 | Global diagnostic bit 0 (word-to-ID select) |
| diag1 | input | 1 | Global diagnostic bit 1 (port-lines-to-ID select) |
| word_valid | input | 1 | Transmit-FIFO word valid |
| word_ready | output | 1 | Always 1: no back-pressure |
| word_data | input | WORD_W | Transmit-FIFO word |
| port_ctl | input | NPORT x 3 | Per-port control field |
| port_ctl_n | input | NPORT | Per-port active-low control line |
| port_mode | input | NPORT | Per-port mode bit |
| card_id | output | NPORT x 6 | Per-port card-ID field |
| pstat | output | NPORT x 3 | Per-port port-status field |
| srstat | output | NPORT x 2 | Per-port summary-status field |

## Verification
The bench builds the block with its defaults: a 26-bit word, two ports and a card ID of 1. With two ports it can catch a port-swap or port-sharing error in the control-line layout. The wide word lets random upper bits confirm that only the low six bits reach the ID fields. Directed sequences cover the held-ID start, entry into each diagnostic mode, a both-bits-first start that tests the word-source default, and a repeated reset. Random cycles then mix all four diagnostic combinations with stalled and active word streams.

// File: rtl/lb_diag_pkg.sv
package lb_diag_pkg;
  localparam int ID_W  = 6;
  localparam int CTL_W = 3;
  localparam int PST_W = 3;
  localparam int SRS_W = 2;
  localparam int ST_W  = PST_W + SRS_W;

  typedef enum logic {
    SEL_WORD = 1'b0,
    SEL_PORT = 1'b1
  } id_sel_e;
endpackage

// File: rtl/lb_word_capture.sv
module lb_word_capture #(
  parameter int WORD_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] cap_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cap_q <= '0;
    else if (valid) cap_q <= data;
  end
endmodule

// File: rtl/lb_mode_ctrl.sv
module lb_mode_ctrl
  import lb_diag_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    diag0,
  input  logic    diag1,
  output logic    show_card,
  output id_sel_e sel,
  output logic    echo
);
  logic    held_q;
  id_sel_e last_q;
  logic    any_diag, one_diag;

  assign any_diag  = diag0 | diag1;
  assign one_diag  = diag0 ^ diag1;
  assign echo      = diag0 & diag1;
  assign show_card = held_q & ~any_diag;
  assign sel       = one_diag ? (diag1 ? SEL_PORT : SEL_WORD) : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b1;
      last_q <= SEL_WORD;
    end else begin
      if (any_diag) held_q <= 1'b0;
      if (one_diag) last_q <= sel;
    end
  end
endmodule

// File: rtl/lb_port_mux.sv
module lb_port_mux
  import lb_diag_pkg::*;
#(
  parameter int CARD_ID = 1
) (
  input  logic             show_card,
  input  id_sel_e          sel,
  input  logic [ID_W-1:0]  cap_low,
  input  logic [CTL_W-1:0] ctl,
  input  logic             ctl_n,
  input  logic             mode,
  output logic [ID_W-1:0]  id
);
  localparam logic [ID_W-1:0] CARD_VAL = ID_W'(CARD_ID);
  localparam int PAD_W = ID_W - CTL_W - 2;

  logic [ID_W-1:0] port_word;
  assign port_word = {{PAD_W{1'b0}}, ctl, ctl_n, mode};

  always_comb begin
    if (show_card)             id = CARD_VAL;
    else if (sel == SEL_PORT)  id = port_word;
    else                       id = cap_low;
  end
endmodule

// File: rtl/lb_status_echo.sv
module lb_status_echo
  import lb_diag_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            echo,
  input  logic [ST_W-1:0] cap_low,
  output logic [ST_W-1:0] stat
);
  logic [ST_W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_q <= '0;
    else if (echo) stat_q <= cap_low;
  end

  assign stat = echo ? cap_low : stat_q;
endmodule

// File: rtl/lb_diag_mux.sv
module lb_diag_mux
  import lb_diag_pkg::*;
#(
  parameter int WORD_W  = 26,
  parameter int NPORT   = 2,
  parameter int CARD_ID = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        diag0,
  input  logic                        diag1,
  input  logic                        word_valid,
  output logic                        word_ready,
  input  logic [WORD_W-1:0]           word_data,
  input  logic [NPORT-1:0][CTL_W-1:0] port_ctl,
  input  logic [NPORT-1:0]            port_ctl_n,
  input  logic [NPORT-1:0]            port_mode,
  output logic [NPORT-1:0][ID_W-1:0]  card_id,
  output logic [NPORT-1:0][PST_W-1:0] pstat,
  output logic [NPORT-1:0][SRS_W-1:0] srstat
);
  logic [WORD_W-1:0] cap_q;
  logic              show_card, echo;
  id_sel_e           sel;
  logic [ST_W-1:0]   stat;

  assign word_ready = 1'b1;

  lb_word_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .valid(word_valid), .data(word_data), .cap_q(cap_q)
  );

  lb_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .diag0(diag0), .diag1(diag1),
    .show_card(show_card), .sel(sel), .echo(echo)
  );

  lb_status_echo u_stat (
    .clk(clk), .rst_n(rst_n), .echo(echo), .cap_low(cap_q[ST_W-1:0]), .stat(stat)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    lb_port_mux #(.CARD_ID(CARD_ID)) u_mux (
      .show_card(show_card),
      .sel(sel),
      .cap_low(cap_q[ID_W-1:0]),
      .ctl(port_ctl[p]),
      .ctl_n(port_ctl_n[p]),
      .mode(port_mode[p]),
      .id(card_id[p])
    );
    assign pstat[p]  = stat[ST_W-1:SRS_W];
    assign srstat[p] = stat[SRS_W-1:0];
  end
endmodule

// File: rtl/lb_diag_mux_chk.sv
module lb_diag_mux_chk
  import lb_diag_pkg::*;
#(
  parameter int WORD_W  = 26,
  parameter int NPORT   = 2,
  parameter int CARD_ID = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        diag0,
  input logic                        diag1,
  input logic                        word_valid,
  input logic [WORD_W-1:0]           word_data,
  input logic [NPORT-1:0][CTL_W-1:0] port_ctl,
  input logic [NPORT-1:0]            port_ctl_n,
  input logic [NPORT-1:0]            port_mode,
  input logic [NPORT-1:0][ID_W-1:0]  card_id,
  input logic [NPORT-1:0][PST_W-1:0] pstat,
  input logic [NPORT-1:0][SRS_W-1:0] srstat
);
  logic [WORD_W-1:0] m_cap;
  logic              m_fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cap   <= '0;
      m_fresh <= 1'b1;
    end else begin
      if (word_valid)     m_cap   <= word_data;
      if (diag0 || diag1) m_fresh <= 1'b0;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    a_r1_reset_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) && !diag0 && !diag1 |->
        card_id[p] == ID_W'(CARD_ID) && pstat[p] == '0 && srstat[p] == '0);

    a_r2_card_held: assert property (@(posedge clk) disable iff (!rst_n)
      m_fresh && !diag0 && !diag1 |-> card_id[p] == ID_W'(CARD_ID));

    a_r4_word_to_id: assert property (@(posedge clk) disable iff (!rst_n)
      diag0 && !diag1 |-> card_id[p] == m_cap[ID_W-1:0]);

    a_r5_port_to_id: assert property (@(posedge clk) disable iff (!rst_n)
      diag1 && !diag0 |->
        card_id[p] == {1'b0, port_ctl[p], port_ctl_n[p], port_mode[p]});

    a_r6_status_echo: assert property (@(posedge clk) disable iff (!rst_n)
      diag0 && diag1 |-> {pstat[p], srstat[p]} == m_cap[ST_W-1:0]);

    a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(diag0 && diag1) && !$rose(rst_n) |->
        pstat[p] == $past(pstat[p]) && srstat[p] == $past(srstat[p]));
  end
endmodule

bind lb_diag_mux lb_diag_mux_chk #(
  .WORD_W(WORD_W), .NPORT(NPORT), .CARD_ID(CARD_ID)
) u_chk (.*);

// File: tb/lb_diag_mux_tb.sv
module lb_diag_mux_tb;
  localparam int WORD_W = 26;
  localparam int NPORT  = 2;
  localparam int CARD   = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic diag0, diag1, word_valid, word_ready;
  logic [WORD_W-1:0] word_data;
  logic [NPORT-1:0][2:0] port_ctl;
  logic [NPORT-1:0] port_ctl_n, port_mode;
  logic [NPORT-1:0][5:0] card_id;
  logic [NPORT-1:0][2:0] pstat;
  logic [NPORT-1:0][1:0] srstat;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic [WORD_W-1:0] m_cap;
  logic m_held, m_last;
  logic [4:0] m_stat;

  always #2.5 clk = ~clk;

  lb_diag_mux #(.WORD_W(WORD_W), .NPORT(NPORT), .CARD_ID(CARD)) u_dut (
    .clk(clk), .rst_n(rst_n), .diag0(diag0), .diag1(diag1),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .port_ctl(port_ctl), .port_ctl_n(port_ctl_n), .port_mode(port_mode),
    .card_id(card_id), .pstat(pstat), .srstat(srstat)
  );

  function automatic logic [5:0] exp_id(int p);
    logic sel;
    if (m_held && !diag0 && !diag1) return 6'(CARD);
    sel = (diag0 ^ diag1) ? diag1 : m_last;
    if (sel) return {1'b0, port_ctl[p], port_ctl_n[p], port_mode[p]};
    return m_cap[5:0];
  endfunction

  function automatic logic [4:0] exp_stat();
    return (diag0 && diag1) ? m_cap[4:0] : m_stat;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string id_req, string st_req);
    for (int p = 0; p < NPORT; p++) begin
      check(id_req, 32'(card_id[p]), 32'(exp_id(p)));
      check(st_req, 32'({pstat[p], srstat[p]}), 32'(exp_stat()));
    end
  endtask

  task automatic model_reset();
    m_cap = '0; m_held = 1'b1; m_last = 1'b0; m_stat = '0;
  endtask

  // drive at negedge, settle, leave stable over the next posedge, then update model
  task automatic drive(logic r, logic d0, logic d1, logic v, logic [WORD_W-1:0] w);
    @(negedge clk);
    rst_n = r; diag0 = d0; diag1 = d1; word_valid = v; word_data = w;
    if (!r) model_reset();
    #1;
  endtask

  task automatic rand_ports();
    for (int p = 0; p < NPORT; p++) begin
      port_ctl[p] = 3'($urandom); port_ctl_n[p] = 1'($urandom); port_mode[p] = 1'($urandom);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (diag0 && diag1) m_stat = m_cap[4:0];
      if (diag0 || diag1) m_held = 1'b0;
      if (diag0 ^ diag1) m_last = diag1;
      if (word_valid) m_cap = word_data;
    end
  end

  function automatic string id_tag();
    if (m_held && !diag0 && !diag1) return "R2";
    if (diag0 && !diag1) return "R4";
    if (diag1 && !diag0) return "R5";
    return "R8";
  endfunction

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; diag0 = 0; diag1 = 0; word_valid = 0; word_data = '0;
    port_ctl = '0; port_ctl_n = '0; port_mode = '0;
    model_reset();

    // R1: reset state
    drive(0, 0, 0, 1, 26'h3ff_ffff);
    for (int p = 0; p < NPORT; p++) begin
      check("R1", 32'(card_id[p]), CARD);
      check("R1", 32'({pstat[p], srstat[p]}), 0);
    end
    drive(0, 0, 0, 0, '0);
    // R9: ready constant
    check("R9", 32'(word_ready), 1);

    // R2: card ID held through word and control activity
    for (int i = 0; i < 6; i++) begin
      rand_ports();
      drive(1, 0, 0, 1, 26'($urandom));
      check("R2", 32'(card_id[0]), CARD);
      check("R2", 32'(card_id[1]), CARD);
    end

    // R5 / R3: port lines, example 0x17 on port 0
    port_ctl[0] = 3'd5; port_ctl_n[0] = 1; port_mode[0] = 1;
    port_ctl[1] = 3'd2; port_ctl_n[1] = 0; port_mode[1] = 1;
    drive(1, 0, 1, 0, '0);
    check("R5", 32'(card_id[0]), 32'h17);
    check("R5", 32'(card_id[1]), 32'h09);
    check("R3", 32'(card_id[0] == 6'(CARD)), 0);
    // R8: both low now shows port source
    drive(1, 0, 0, 0, '0);
    check("R8", 32'(card_id[0]), 32'h17);
    check("R3", 32'(card_id[1] != 6'(CARD)), 1);

    // R4 with a word whose upper bits are noisy
    drive(1, 0, 0, 1, 26'h2a5_5f2d);
    drive(1, 1, 0, 0, '0);
    check("R4", 32'(card_id[0]), 32'h2d);
    check("R4", 32'(card_id[1]), 32'h2d);
    // R9: no valid -> capture holds
    drive(1, 1, 0, 0, 26'h000_0011);
    check("R9", 32'(card_id[0]), 32'h2d);

    // R6: echo 0x2d[4:0]=0x0d -> pstat=3, srstat=1
    drive(1, 1, 1, 0, '0);
    check("R6", 32'(pstat[0]), 3); check("R6", 32'(srstat[0]), 1);
    check("R6", 32'(pstat[1]), 3); check("R6", 32'(srstat[1]), 1);
    // R7: hold after echo, even with new words
    drive(1, 0, 0, 1, 26'h000_0012);
    drive(1, 0, 1, 0, '0);
    check("R7", 32'({pstat[1], srstat[1]}), 32'h0d);
    check("R7", 32'({pstat[0], srstat[0]}), 32'h0d);

    // R1/R3: repeated reset restores card ID and clears status
    drive(0, 0, 0, 0, '0);
    drive(1, 0, 0, 0, '0);
    check("R3", 32'(card_id[0]), CARD);
    check("R1", 32'({pstat[0], srstat[0]}), 0);

    // R8: both bits first after reset -> word source default
    drive(1, 0, 0, 1, 26'h100_0027);
    drive(1, 1, 1, 0, '0);
    check("R8", 32'(card_id[0]), 32'h27);
    check("R6", 32'({pstat[0], srstat[0]}), 32'h07);
    drive(1, 0, 0, 0, '0);
    check("R8", 32'(card_id[1]), 32'h27);
    check("R7", 32'({pstat[1], srstat[1]}), 32'h07);

    // random mix
    for (int i = 0; i < 400; i++) begin
      rand_ports();
      if (($urandom % 50) == 0) drive(0, 0, 0, 0, '0);
      else drive(1, 1'($urandom), 1'($urandom), 1'($urandom), 26'($urandom));
      check_all(id_tag(), (diag0 && diag1) ? "R6" : "R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule